// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus that behaves like a byte-wide serial EEPROM. It listens on the clock and data lines and drives the data line only as an open-drain low, through an output enable. It answers to a device select byte that combines a fixed device type with three chip-select pins. A write command carries a two-byte word address and then one or more data bytes. A read command returns bytes from the current address, either straight away or after a dummy write that sets the address. A read continues for as long as the master acknowledges each byte.

Write data is collected in a 128-byte page buffer and is committed to the array only when the master sends STOP. The commit then starts a programming interval, counted in system clock cycles. While that interval runs, the slave ignores its own select byte. A write-protect input stops the commit but has no effect on reads. The bus lines pass through two-flop synchronisers into the system clock domain, and all edge and condition detection works on the synchronised copies.

There are no valid/ready streams at this block's edge. The only data path is the serial bus, whose pace the master sets through the clock line. The slave never stretches the clock, so it applies no back-pressure.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A START (data falling while clock high) restarts decoding at the first bit of a select byte from any state, even in the middle of a byte. A STOP (data rising while clock high) returns the slave to idle.
- R2: The select byte, MSB first, is 1010, then chip_sel_i[2:0], then a read/write bit (1 = read). On a match the slave pulls SDA low during the ninth clock. On a mismatch it does not acknowledge and ignores the bus until the next START.
- R3: A write of select, address high byte, address low byte, one data byte and STOP stores that byte at the 16-bit word address. The array is indexed by the low MEM_AW address bits.
- R4: Successive data bytes in one write go to successive addresses, and only the low 7 address bits advance, wrapping inside the 128-byte page. Bytes of the page that were not loaded keep their old contents.
- R5: Data reaches the array only on STOP. A repeated START before STOP discards the buffered bytes, and no programming interval follows.
- R6: While wp_i is high at STOP, the array is left unchanged and no programming interval starts. Reads are not affected by wp_i.
- R7: For PROG_CYCLES clock cycles after a programming STOP, the slave does not acknowledge its select byte. After that it acknowledges again.
- R8: A random read (a write of the address, then a repeated START and a read select) returns the byte at that address. The byte is sent MSB first, and each bit is driven after a falling clock edge.
- R9: A read that is not preceded by an address write returns the byte at the address one past the last byte read or written.
- R10: While the master acknowledges, a read goes on with the next address, and the full 16-bit address rolls over from 0xFFFF to 0x0000. After a master NACK the slave releases SDA.
- R11: sda_oe_o is low out of reset and changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | When high, the data line is pulled low |
| chip_sel_i | input | 3 | Chip-select address bits compared against the select byte |
| wp_i | input | 1 | Write protect; high blocks programming |

## Verification
The bench drives a master at the bit level and follows every transaction with a behavioural byte map. It targets the page wrap at offset 127, where a design that carries into the upper address bits would corrupt the next page. It also targets the 0xFFFF read rollover, which an in-page-only counter would get wrong. A select byte sent right after a write STOP must be refused, and one sent after write protect or after a discarded repeated-START write must be accepted. A slave that programmed anyway would either acknowledge too early or wrongly refuse. A START in the middle of a byte and a wrong chip select show whether the bit counter and the match logic restart cleanly. On every clock the bench also checks that the data enable never moves while the clock is high.

// File: rtl/eeprom_slave_pkg.sv
package eeprom_slave_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DACK, S_AHI, S_AHACK, S_ALO, S_ALACK,
    S_WR, S_WACK, S_RD, S_RACK
  } slv_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/twi_line_cond.sv
module twi_line_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  localparam int NLINE = 2;
  logic [NLINE-1:0] raw, meta, sync, prev;

  assign raw = {sda_i, scl_i};

  genvar g;
  generate
    for (g = 0; g < NLINE; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta[g] <= 1'b1;
          sync[g] <= 1'b1;
          prev[g] <= 1'b1;
        end else begin
          meta[g] <= raw[g];
          sync[g] <= meta[g];
          prev[g] <= sync[g];
        end
      end
    end
  endgenerate

  assign scl_s    = sync[0];
  assign sda_s    = sync[1];
  assign scl_rise = sync[0] & ~prev[0];
  assign scl_fall = ~sync[0] & prev[0];
  assign start_p  = sync[0] & prev[0] & prev[1] & ~sync[1];
  assign stop_p   = sync[0] & prev[0] & ~prev[1] & sync[1];

  a_r1_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_p && stop_p));
endmodule

// File: rtl/eeprom_prog_timer.sv
module eeprom_prog_timer #(
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain <= '0;
    else if (start_i)          remain <= CW'(PROG_CYCLES);
    else if (remain != '0)     remain <= remain - 1'b1;
  end

  assign busy_o = (remain != '0);

  a_r7_no_restart_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
endmodule

// File: rtl/eeprom_page_store.sv
module eeprom_page_store #(
  parameter int PAGE_AW = 7,
  parameter int MEM_AW  = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      we_i,
  input  logic [PAGE_AW-1:0]        widx_i,
  input  logic [7:0]                wdata_i,
  input  logic                      commit_i,
  input  logic [MEM_AW-PAGE_AW-1:0] page_i,
  input  logic [MEM_AW-1:0]         raddr_i,
  output logic [7:0]                rdata_o
);
  localparam int PAGE_N = 1 << PAGE_AW;
  localparam int MEM_N  = 1 << MEM_AW;

  logic [7:0]        pbuf [PAGE_N];
  logic [PAGE_N-1:0] vld;
  logic [7:0]        mem  [MEM_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld <= '0;
    else if (clr_i) vld <= '0;
    else if (we_i)  vld[widx_i] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we_i) pbuf[widx_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (commit_i) begin
      for (int i = 0; i < PAGE_N; i++) begin
        if (vld[i]) mem[{page_i, PAGE_AW'(i)}] <= pbuf[i];
      end
    end
  end

  assign rdata_o = mem[raddr_i];

  a_r5_no_write_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |-> !we_i);
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eeprom_slave_pkg::*;
#(
  parameter int MEM_AW      = 11,
  parameter int PROG_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] chip_sel_i,
  input  logic       wp_i
);
  localparam int ADDR_W  = 16;
  localparam int PAGE_AW = 7;

  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic busy, commit, buf_we, buf_clr, sel_hit;
  slv_state_e st;
  logic [2:0] bit_cnt;
  logic [7:0] sh, rd_sh, rd_data;
  logic byte_full, rw_bit, m_nack, wr_pend, oe_q;
  logic [ADDR_W-1:0] addr;

  twi_line_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  eeprom_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(commit), .busy_o(busy)
  );

  eeprom_page_store #(.PAGE_AW(PAGE_AW), .MEM_AW(MEM_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .we_i(buf_we),
    .widx_i(addr[PAGE_AW-1:0]), .wdata_i(sh), .commit_i(commit),
    .page_i(addr[MEM_AW-1:PAGE_AW]), .raddr_i(addr[MEM_AW-1:0]),
    .rdata_o(rd_data)
  );

  assign sel_hit = (sh[7:1] == {DEV_TYPE, chip_sel_i}) && !busy;
  assign buf_clr = start_p || stop_p;
  assign buf_we  = (st == S_WR) && byte_full && scl_fall && !start_p && !stop_p;
  assign commit  = stop_p && wr_pend && !wp_i && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_pend <= 1'b0;
    else if (buf_clr) wr_pend <= 1'b0;
    else if (buf_we)  wr_pend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bit_cnt   <= '0;
      sh        <= '0;
      rd_sh     <= '0;
      byte_full <= 1'b0;
      rw_bit    <= 1'b0;
      m_nack    <= 1'b1;
      addr      <= '0;
      oe_q      <= 1'b0;
    end else if (start_p) begin
      st        <= S_DEV;
      bit_cnt   <= '0;
      byte_full <= 1'b0;
      oe_q      <= 1'b0;
    end else if (stop_p) begin
      st        <= S_IDLE;
      byte_full <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_AHI, S_ALO, S_WR: begin
          if (scl_rise) begin
            sh      <= {sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == 3'd7) byte_full <= 1'b1;
          end else if (scl_fall && byte_full) begin
            byte_full <= 1'b0;
            case (st)
              S_DEV: begin
                if (sel_hit) begin
                  oe_q   <= 1'b1;
                  rw_bit <= sh[0];
                  st     <= S_DACK;
                end else begin
                  st <= S_IDLE;
                end
              end
              S_AHI: begin
                addr[15:8] <= sh;
                oe_q       <= 1'b1;
                st         <= S_AHACK;
              end
              S_ALO: begin
                addr[7:0] <= sh;
                oe_q      <= 1'b1;
                st        <= S_ALACK;
              end
              default: begin
                addr[PAGE_AW-1:0] <= addr[PAGE_AW-1:0] + 1'b1;
                oe_q              <= 1'b1;
                st                <= S_WACK;
              end
            endcase
          end
        end
        S_DACK: begin
          if (scl_fall) begin
            if (rw_bit) begin
              rd_sh   <= rd_data;
              oe_q    <= ~rd_data[7];
              addr    <= addr + 1'b1;
              bit_cnt <= '0;
              st      <= S_RD;
            end else begin
              oe_q <= 1'b0;
              st   <= S_AHI;
            end
          end
        end
        S_AHACK: begin
          if (scl_fall) begin
            oe_q <= 1'b0;
            st   <= S_ALO;
          end
        end
        S_ALACK, S_WACK: begin
          if (scl_fall) begin
            oe_q <= 1'b0;
            st   <= S_WR;
          end
        end
        S_RD: begin
          if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              oe_q    <= 1'b0;
              bit_cnt <= '0;
              st      <= S_RACK;
            end else begin
              oe_q    <= ~rd_sh[6];
              rd_sh   <= {rd_sh[6:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            m_nack <= sda_s;
          end else if (scl_fall) begin
            if (!m_nack) begin
              rd_sh   <= rd_data;
              oe_q    <= ~rd_data[7];
              addr    <= addr + 1'b1;
              bit_cnt <= '0;
              st      <= S_RD;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  a_r1_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (st == S_DEV && bit_cnt == 3'd0));
  a_r11_oe_hold_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_p) && !$past(stop_p)) |-> $stable(sda_oe_o));
  a_r7_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DACK) |-> !busy);
  a_r6_wp_blocks_prog: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_i));
  a_r2_drive_states: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (st inside {S_DACK, S_AHACK, S_ALACK, S_WACK, S_RD}));
endmodule

// File: tb/serial_eeprom_slave_bench.sv
module serial_eeprom_slave_bench;
  localparam int MEM_AW = 11;
  localparam int PROG   = 2000;
  localparam int Q      = 10;
  localparam logic [2:0] CS = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic [2:0] cs = CS;
  logic sda_oe;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_oe;
  always #2 clk = ~clk;

  serial_eeprom_slave #(.MEM_AW(MEM_AW), .PROG_CYCLES(PROG)) u_serial_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .chip_sel_i(cs), .wp_i(wp)
  );

  int total = 0;
  int bad = 0;
  int mon_bad = 0;
  bit done = 1'b0;
  logic [7:0] model_mem [int];
  int model_addr = 0;
  logic [7:0] wq[$];
  logic prev_scl = 1'b1;
  logic prev_oe = 1'b0;

  // R11: enable may only move while the bus clock is low, checked every clock
  always @(negedge clk) begin
    if (rst_n && scl && prev_scl && (sda_oe !== prev_oe)) mon_bad++;
    prev_scl <= scl;
    prev_oe  <= sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int midx(input int a);
    return a & ((1 << MEM_AW) - 1);
  endfunction

  task automatic qwait;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; qwait;
    scl = 1'b1;   qwait;
    sda_m = 1'b0; qwait;
    scl = 1'b0;   qwait;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; qwait;
    scl = 1'b1;   qwait;
    sda_m = 1'b1; qwait; qwait;
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    sda_m = b;  qwait;
    scl = 1'b1; qwait;
    s = sda_bus; qwait;
    scl = 1'b0; qwait;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic m_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      v[i] = s;
    end
    bit_xfer(~m_ack, s);
  endtask

  function automatic logic [7:0] dev(input logic rw);
    return {4'b1010, CS, rw};
  endfunction

  task automatic prog_wait;
    repeat (PROG + 400) @(negedge clk);
  endtask

  task automatic set_addr(input int a, input string tag);
    logic ack;
    bus_start;
    put_byte(dev(1'b0), ack); chk(ack, tag, ack, 1);
    put_byte(a[15:8], ack);   chk(ack, tag, ack, 1);
    put_byte(a[7:0], ack);    chk(ack, tag, ack, 1);
    model_addr = a;
  endtask

  task automatic write_cmd(input int a, input string tag);
    logic ack;
    int base, off, n;
    set_addr(a, tag);
    foreach (wq[k]) begin
      put_byte(wq[k], ack);
      chk(ack, tag, ack, 1);
    end
    bus_stop;
    base = a & 'hFF80;
    off  = a & 127;
    n    = wq.size();
    if (!wp) begin
      foreach (wq[k]) model_mem[midx(base | ((off + k) & 127))] = wq[k];
    end
    model_addr = (n == 0) ? a : (base | ((off + n) & 127));
  endtask

  task automatic read_run(input int n, input string tag);
    logic ack;
    logic [7:0] v, e;
    bus_start;
    put_byte(dev(1'b1), ack);
    chk(ack, tag, ack, 1);
    for (int k = 0; k < n; k++) begin
      get_byte(k != n - 1, v);
      e = model_mem[midx(model_addr)];
      chk(v === e, tag, v, e);
      model_addr = (model_addr + 1) & 'hFFFF;
    end
    chk(sda_oe == 1'b0, {tag, " release after NACK (R10)"}, sda_oe, 0);
    bus_stop;
  endtask

  task automatic probe_select(input logic exp_ack, input string tag);
    logic ack;
    bus_start;
    put_byte(dev(1'b0), ack);
    chk(ack == exp_ack, tag, ack, exp_ack);
    bus_stop;
  endtask

  initial begin
    logic ack;
    logic s;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 reset enable", sda_oe, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R2: wrong chip select is not acknowledged and the line stays released
    bus_start;
    put_byte({4'b1010, ~CS, 1'b0}, ack);
    chk(!ack, "R2 select mismatch", ack, 0);
    chk(sda_oe == 1'b0, "R2 ignored after mismatch", sda_oe, 0);
    bus_stop;

    // R3 byte write, R7 busy window
    wq = '{8'hA5};
    write_cmd('h0123, "R3 byte write");
    probe_select(1'b0, "R7 select refused while programming");
    prog_wait;
    probe_select(1'b1, "R7 select accepted after programming");
    set_addr('h0123, "R8 address");
    read_run(1, "R8 random read");

    // R4 page write, R10 sequential read, R9 current address
    wq = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14};
    write_cmd('h0230, "R4 page write");
    prog_wait;
    set_addr('h0230, "R10 address");
    read_run(4, "R10 sequential read");
    read_run(1, "R9 current address read");

    // R4 wrap inside the page
    wq = '{8'h61, 8'h62, 8'h63, 8'h64};
    write_cmd('h027E, "R4 wrap write");
    prog_wait;
    set_addr('h027E, "R4 address");
    read_run(2, "R4 page tail");
    set_addr('h0200, "R4 address");
    read_run(2, "R4 wrapped head");
    set_addr('h0230, "R4 address");
    read_run(1, "R4 partial page untouched");

    // R5: repeated START discards buffered data
    wq = '{8'h11};
    write_cmd('h0300, "R5 setup");
    prog_wait;
    set_addr('h0300, "R5 aborted write");
    put_byte(8'h77, ack);
    chk(ack, "R5 data ack", ack, 1);
    set_addr('h0300, "R5 repeated start");
    bus_stop;
    probe_select(1'b1, "R5 no programming after discard");
    set_addr('h0300, "R5 address");
    read_run(1, "R5 data unchanged");

    // R6: write protect blocks programming but not reads
    wp = 1'b1;
    wq = '{8'h99};
    write_cmd('h0300, "R6 protected write");
    probe_select(1'b1, "R6 no busy window");
    set_addr('h0300, "R6 address");
    read_run(1, "R6 read under protect");
    wp = 1'b0;

    // R10: 16-bit rollover during sequential read
    wq = '{8'hC3};
    write_cmd('hFFFF, "R10 top byte");
    prog_wait;
    wq = '{8'h3C};
    write_cmd('h0000, "R10 bottom byte");
    prog_wait;
    set_addr('hFFFF, "R10 address");
    read_run(2, "R10 rollover read");

    // R1: START in the middle of a byte restarts decoding
    bus_start;
    bit_xfer(1'b0, s);
    bit_xfer(1'b1, s);
    bit_xfer(1'b0, s);
    bit_xfer(1'b0, s);
    set_addr('h0123, "R1 restart mid-byte");
    read_run(1, "R1 read after restart");

    chk(mon_bad == 0, "R11 enable moved while clock high", mon_bad, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule